// File: doc/BRIEF.md
# Pause-Referenced Response Delay Timer

This block times the start of a card's bit-synchronous reply. The reply does not count from the bit clock. It counts from the moment the reader's last modulation pause ends. A delay counter advances once for each carrier-cycle enable. It returns to zero whenever the demodulated reader signal changes level. When the count equals a programmed start value, the block emits a one-cycle trigger for the response transmitter. The same event opens a gate on a free-running enable that ticks once every sixteen carrier cycles, which is the subcarrier rate. A second programmed value shapes an auxiliary pulse. That pulse begins when a pause begins and ends when the counter reaches the second value.

Control logic outside the block raises the arm input once the reader frame has ended. While arm is low, the counter is held at zero and every output stays quiet. After a trigger, the timer stays silent until the next pause edge restarts it. A late pause therefore moves the trigger so that it lines up with that last pause.

Top module: `resp_delay_timer`

## Requirements
- R1: The delay counter advances only in cycles where `carrier_en` is 1. With `carrier_en` held at 0 after a restart, no trigger appears. Once `carrier_en` returns to 1 on every cycle, the trigger is sampled high after the (cmp_start+1)-th following clock edge.
- R2: A rising edge of `demod_in` (0 = pause, 1 = carrier present) restarts the count. A new pause in the middle of a count moves the trigger so that it is measured from the newest rising edge.
- R3: With `arm`=1 and `carrier_en`=1 every cycle, `tx_start` is high for exactly one cycle. It is sampled high after the (cmp_start+2)-th clock edge, counting the edge that captures the pause's rising edge as the first. It never fires while a pause is in progress.
- R4: After a trigger, `tx_start` does not fire again, even after the counter saturates at its all-ones value. Only the next pause edge allows another trigger.
- R5: A falling edge of `demod_in` sets `aux_out`, starting with the sample after the capturing edge. While the pause lasts, `aux_out` stays high for exactly cmp_aux_clr+1 samples.
- R6: `sub_en` is low until `tx_start` fires. After that, it pulses exactly every 16 carrier-enabled cycles, and only in cycles where `carrier_en` is 1. It goes low after the next pause edge or when arm is dropped.
- R7: While `arm` is 0, `tx_start`, `aux_out` and `sub_en` stay low, whatever `demod_in` does.
- R8: After reset, `tx_start`, `aux_out` and `sub_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_en | input | 1 | One-cycle enable per carrier period |
| demod_in | input | 1 | Demodulated reader signal, 0 during a pause |
| arm | input | 1 | Enables the timer once the reader frame is over |
| cmp_start | input | CNT_W | Count at which the transmit trigger fires |
| cmp_aux_clr | input | CNT_W | Count at which the auxiliary pulse ends |
| tx_start | output | 1 | One-cycle transmit-start trigger |
| sub_en | output | 1 | Gated subcarrier-rate enable |
| aux_out | output | 1 | Auxiliary pulse, set at pause start |

## Verification
The bench sweeps every start value of a 6-bit counter and checks the exact sample in which the trigger appears. It also checks that exactly one trigger fires in a long window. An off-by-one in the counter or the output register shows up as a shifted sample, and a missing rearm latch shows up as repeated pulses once the counter saturates. A sweep of the auxiliary clear value catches a pulse that is one cycle short or long. Other checks cover a counter that ignores `carrier_en`, a restart that ignores a late pause, a subcarrier gate that opens early or at the wrong spacing, and outputs that leak while the timer is disarmed.

// File: rtl/rdt_pkg.sv
// Shared types for the pause-referenced response delay timer.
package rdt_pkg;
    // Edge events decoded from the demodulated reader signal.
    typedef struct packed {
        logic rise;   // pause ended, carrier back
        logic fall;   // pause started
    } pause_edge_t;
endpackage

// File: rtl/rdt_edge_detect.sv
// Decodes pause start and pause end from the demodulated reader signal.
// Assumes demod_in is already synchronous to clk; 0 means a pause.
module rdt_edge_detect
    import rdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        demod_in,
    output pause_edge_t edges,
    output logic        carrier_on
);
    logic demod_q;

    // Remember the previous level; carrier assumed present out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) demod_q <= 1'b1;
        else        demod_q <= demod_in;
    end

    // Edge decode against the remembered level.
    always_comb begin
        edges.rise = demod_in & ~demod_q;
        edges.fall = ~demod_in & demod_q;
    end

    assign carrier_on = demod_q;
endmodule

// File: rtl/rdt_delay_counter.sv
// Saturating delay counter clocked by carrier-cycle enables.
// Restarts at zero on any pause edge and is held at zero while disarmed.
module rdt_delay_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             carrier_en,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count carrier cycles since the latest pause edge, stopping at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt <= '0;
        else if (!arm || restart)               cnt <= '0;
        else if (carrier_en && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rdt_start_ctrl.sv
// Compares the delay count with the two programmed values. It produces the
// one-shot transmit trigger, the latch that blocks repeats until the next
// pause edge, and the auxiliary pulse. Compare values are assumed stable
// while a count is running.
module rdt_start_ctrl #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             carrier_on,
    input  logic             restart,
    input  logic             fall,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_start,
    input  logic [CNT_W-1:0] cmp_aux_clr,
    output logic             tx_start,
    output logic             tx_active,
    output logic             aux_out
);
    logic start_hit;
    logic aux_hit;

    // Match conditions; a trigger needs carrier present and no prior trigger.
    always_comb begin
        start_hit = arm && carrier_on && !restart && !tx_active && (cnt == cmp_start);
        aux_hit   = !restart && (cnt == cmp_aux_clr);
    end

    // Register the trigger and hold the fired state until the next restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_start  <= 1'b0;
            tx_active <= 1'b0;
        end else begin
            tx_start  <= start_hit;
            tx_active <= arm && !restart && (tx_active || start_hit);
        end
    end

    // Auxiliary pulse: set at pause start, cleared at the second compare.
    always_ff @(posedge clk) begin
        if (!rst_n)       aux_out <= 1'b0;
        else if (!arm)    aux_out <= 1'b0;
        else if (fall)    aux_out <= 1'b1;
        else if (aux_hit) aux_out <= 1'b0;
    end
endmodule

// File: rtl/rdt_sub_gate.sv
// Free-running subcarrier-rate divider of the carrier enable, gated by the
// fired state of the timer. SUB_DIV selects the division ratio.
module rdt_sub_gate #(
    parameter int SUB_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_en,
    input  logic gate_on,
    output logic sub_en
);
    generate
        if (SUB_DIV <= 1) begin : g_passthru
            // No division: every carrier cycle is a subcarrier tick.
            assign sub_en = gate_on && carrier_en;
        end else begin : g_divide
            localparam int              SUB_W    = $clog2(SUB_DIV);
            localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_DIV - 1);
            logic [SUB_W-1:0] sub_cnt;

            // Divider runs regardless of the gate so its phase is free-running.
            always_ff @(posedge clk) begin
                if (!rst_n)          sub_cnt <= '0;
                else if (carrier_en) sub_cnt <= (sub_cnt == SUB_LAST) ? '0 : sub_cnt + 1'b1;
            end

            // Emit the tick only while the gate is open.
            assign sub_en = gate_on && carrier_en && (sub_cnt == SUB_LAST);
        end
    endgenerate
endmodule

// File: rtl/resp_delay_timer.sv
// Top of the pause-referenced response delay timer. The delay count restarts
// at every pause edge. At the start compare it triggers the transmitter once
// and opens the subcarrier enable. Assumes carrier_en is a one-cycle strobe
// and that all inputs are synchronous to clk.
module resp_delay_timer
    import rdt_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int SUB_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_en,
    input  logic             demod_in,
    input  logic             arm,
    input  logic [CNT_W-1:0] cmp_start,
    input  logic [CNT_W-1:0] cmp_aux_clr,
    output logic             tx_start,
    output logic             sub_en,
    output logic             aux_out
);
    pause_edge_t      edges;
    logic             carrier_on;
    logic             edge_any;
    logic             tx_active;
    logic [CNT_W-1:0] cnt;

    assign edge_any = edges.rise | edges.fall;

    rdt_edge_detect i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .demod_in   (demod_in),
        .edges      (edges),
        .carrier_on (carrier_on)
    );

    rdt_delay_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .carrier_en (carrier_en),
        .restart    (edge_any),
        .cnt        (cnt)
    );

    rdt_start_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .carrier_on  (carrier_on),
        .restart     (edge_any),
        .fall        (edges.fall),
        .cnt         (cnt),
        .cmp_start   (cmp_start),
        .cmp_aux_clr (cmp_aux_clr),
        .tx_start    (tx_start),
        .tx_active   (tx_active),
        .aux_out     (aux_out)
    );

    rdt_sub_gate #(.SUB_DIV(SUB_DIV)) i_sub (
        .clk        (clk),
        .rst_n      (rst_n),
        .carrier_en (carrier_en),
        .gate_on    (tx_active),
        .sub_en     (sub_en)
    );
endmodule

// File: rtl/rdt_checker.sv
// Temporal checks on the response delay timer, attached by bind.
module rdt_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             carrier_en,
    input logic             demod_in,
    input logic             edge_any,
    input logic [CNT_W-1:0] cnt,
    input logic             tx_start,
    input logic             aux_out,
    input logic             sub_en
);
    // Counter frozen when no carrier enable and no restart.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !carrier_en && !edge_any) |=> $stable(cnt));

    // Any pause edge returns the count to zero.
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && edge_any) |=> (cnt == '0));

    // Trigger lasts a single cycle.
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // Pause start raises the auxiliary output.
    p_fall_aux_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !demod_in && $past(demod_in)) |=> aux_out);

    // Subcarrier tick only in carrier-enabled cycles.
    p_sub_carrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en |-> carrier_en);

    // Disarmed timer stays quiet.
    p_disarm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (!tx_start && !aux_out && !sub_en));
endmodule

bind resp_delay_timer rdt_checker #(.CNT_W(CNT_W)) i_rdt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .carrier_en (carrier_en),
    .demod_in   (demod_in),
    .edge_any   (edge_any),
    .cnt        (cnt),
    .tx_start   (tx_start),
    .aux_out    (aux_out),
    .sub_en     (sub_en)
);

// File: tb/test_resp_delay_timer.sv
module test_resp_delay_timer;
    localparam int CNT_W = 6;
    localparam int SUB   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             carrier_en = 1'b1;
    logic             demod_in = 1'b1;
    logic             arm = 1'b0;
    logic [CNT_W-1:0] cmp_start = '0;
    logic [CNT_W-1:0] cmp_aux_clr = '0;
    logic             tx_start, sub_en, aux_out;

    int total = 0;
    int fails = 0;
    int tx_first, tx_count, aux_first, aux_count, sub_first, sub_count, sub_last, gap_bad;

    always #5 clk = ~clk;

    resp_delay_timer #(.CNT_W(CNT_W), .SUB_DIV(SUB)) i_resp_delay_timer (
        .clk(clk), .rst_n(rst_n), .carrier_en(carrier_en), .demod_in(demod_in),
        .arm(arm), .cmp_start(cmp_start), .cmp_aux_clr(cmp_aux_clr),
        .tx_start(tx_start), .sub_en(sub_en), .aux_out(aux_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Step through win clock edges and record what the outputs did.
    task automatic watch(input int win);
        tx_first = 0; tx_count = 0; aux_first = 0; aux_count = 0;
        sub_first = 0; sub_count = 0; sub_last = 0; gap_bad = 0;
        for (int n = 1; n <= win; n++) begin
            tick();
            if (tx_start) begin
                if (tx_count == 0) tx_first = n;
                tx_count++;
            end
            if (aux_out) begin
                if (aux_count == 0) aux_first = n;
                aux_count++;
            end
            if (sub_en) begin
                if (sub_count == 0) sub_first = n;
                else if (n - sub_last != SUB) gap_bad++;
                sub_last = n;
                sub_count++;
            end
        end
    endtask

    task automatic pause(input int len);
        demod_in = 1'b0;
        repeat (len) tick();
        demod_in = 1'b1;
    endtask

    initial begin
        #1_000_000;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        fails++;
        total++;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R8: reset state
        check(!tx_start && !aux_out && !sub_en, "R8 reset", {tx_start, aux_out, sub_en}, 0);
        rst_n = 1'b1;
        tick();
        check(!tx_start && !aux_out && !sub_en, "R8 after reset", {tx_start, aux_out, sub_en}, 0);

        arm = 1'b1;
        cmp_aux_clr = 6'd2;
        // R3/R4: sweep every start value; exactly one trigger at C+2
        for (int c = 0; c < 64; c++) begin
            cmp_start = CNT_W'(c);
            pause(3);
            watch(c + 20);
            check(tx_first == c + 2, "R3 latency", tx_first, c + 2);
            check(tx_count == 1, "R4 single trigger", tx_count, 1);
        end

        // R4: long wait past saturation, no repeat
        cmp_start = 6'd5;
        pause(2);
        watch(150);
        check(tx_count == 1, "R4 no repeat after saturation", tx_count, 1);

        // R2: late pause restarts the delay
        cmp_start = 6'd30;
        pause(3);
        watch(10);
        check(tx_count == 0, "R2 no early trigger", tx_count, 0);
        pause(2);
        watch(50);
        check(tx_first == 32, "R2 measured from last pause", tx_first, 32);
        check(tx_count == 1, "R2 single trigger", tx_count, 1);

        // R5: sweep auxiliary clear value within a long pause
        cmp_start = 6'd63;
        for (int b = 0; b <= 40; b++) begin
            cmp_aux_clr = CNT_W'(b);
            demod_in = 1'b0;
            watch(b + 10);
            check(aux_first == 1, "R5 aux start", aux_first, 1);
            check(aux_count == b + 1, "R5 aux width", aux_count, b + 1);
            demod_in = 1'b1;
            watch(3);
        end

        // R1: counter frozen without carrier enables
        cmp_start = 6'd8;
        demod_in = 1'b0;
        repeat (3) tick();
        demod_in = 1'b1;
        carrier_en = 1'b0;
        watch(40);
        check(tx_count == 0, "R1 frozen without carrier", tx_count, 0);
        carrier_en = 1'b1;
        watch(30);
        check(tx_first == 9, "R1 resumes counting", tx_first, 9);

        // R6: subcarrier gate opens with the trigger
        cmp_start = 6'd10;
        pause(3);
        watch(90);
        check(tx_first == 12, "R6 trigger position", tx_first, 12);
        check(sub_count >= 4, "R6 sub pulses present", sub_count, 4);
        check(sub_first >= tx_first && sub_first < tx_first + SUB, "R6 first sub after trigger", sub_first, tx_first);
        check(gap_bad == 0, "R6 sub spacing", gap_bad, 0);
        demod_in = 1'b0;
        watch(20);
        check(sub_count == 0, "R6 gate closed by pause", sub_count, 0);
        demod_in = 1'b1;
        watch(5);

        // R6/R7: disarm closes an open gate
        pause(3);
        watch(30);
        check(tx_count == 1, "R7 setup trigger", tx_count, 1);
        arm = 1'b0;
        watch(40);
        check(sub_count == 0, "R7 sub quiet when disarmed", sub_count, 0);

        // R7: pauses while disarmed produce nothing
        pause(3);
        watch(30);
        check(tx_count == 0, "R7 no trigger disarmed", tx_count, 0);
        check(aux_count == 0, "R7 no aux disarmed", aux_count, 0);
        check(sub_count == 0, "R7 no sub disarmed", sub_count, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule